// File: doc/BRIEF.md
# Function-Decoded Backplane Bus Slave

This block is the target side of an asynchronous backplane bus with a 16-bit data path. A master puts an 11-bit subaddress and a 4-bit function code on the bus and then pulls a strobe low. The block passes the strobe through a synchroniser and acts on its falling edge. At that point it captures the subaddress, the function code and the write data. The function code then decides what the cycle does. It can pop the readout FIFO, push into that FIFO, pulse a board-wide initialise-and-clear, or forward a read or write to the register targets over an internal request/response port.

When the access is complete, the block drives the acknowledge low and returns a Q flag. Q says whether the target accepted the access. On a read it also enables its data driver for the master. The acknowledge stays low until the master raises the strobe again, so each strobe low period carries exactly one transfer.

Top module: `bus_fn_slave`

## Requirements
- R1: While reset is held, and immediately after it is released, the outputs are idle: acknowledge high, data output enable low, Q low, and no register request, FIFO pop, FIFO push or initialise pulse.
- R2: Function code 0 with a non-empty FIFO pops exactly one word. The block returns that word, the head at the time of the access, as read data with Q=1.
- R3: Function code 0 with an empty FIFO returns data 0x0000 with Q=0 and issues no pop.
- R4: Function code 8 pushes the captured write data once if the FIFO is not full, and returns Q=1. If the FIFO is full, it issues no push and returns Q=0.
- R5: Function code 15 issues exactly one initialise pulse (which also clears the FIFO), returns Q=1, and makes no register request.
- R6: Function codes 1 to 7 (most significant function bit 0) make one register request with write-enable 0 and the captured subaddress and function. The read data and Q are the target's response data and accept flag.
- R7: Function codes 9 to 14 (most significant function bit 1) make one register request with write-enable 1 and the captured write data. Q is the target's accept flag, and the data driver stays disabled.
- R8: The data output enable is high only during cycles whose function code is 0 to 7. It rises with the acknowledge and falls when the acknowledge is released.
- R9: The acknowledge goes low only after a strobe falling edge and stays low while the strobe is low. It returns high on the third clock edge after the strobe rises, which is the synchroniser depth plus one.
- R10: A register request stays asserted, with subaddress, function, write-enable and write data unchanged, until the target answers with its acknowledge. Each bus cycle makes at most one request.
- R11: Changes on the subaddress, function or data inputs after the strobe falling edge has been taken do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strobe_n | input | 1 | Asynchronous transfer strobe from the master, active low |
| bus_subaddr | input | 11 | Subaddress from the master |
| bus_func | input | 4 | Function code from the master |
| bus_wdata | input | 16 | Data bus as seen by the slave (write data) |
| bus_rdata | output | 16 | Read data toward the data bus |
| bus_rdata_oe | output | 1 | Enable for the data bus driver |
| bus_ack_n | output | 1 | Acknowledge to the master, active low |
| bus_q | output | 1 | Access-accepted flag, valid while acknowledge is low |
| reg_req | output | 1 | Register access request, held until reg_ack |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | 11 | Captured subaddress for the register access |
| reg_func | output | 4 | Captured function code for the register access |
| reg_wdata | output | 16 | Captured write data for the register access |
| reg_ack | input | 1 | Register target response valid |
| reg_ok | input | 1 | Register target accepted the access |
| reg_rdata | input | 16 | Register target read data |
| fifo_empty | input | 1 | Readout FIFO is empty |
| fifo_full | input | 1 | Readout FIFO is full |
| fifo_head | input | 16 | Head word of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Pop the head word, one cycle |
| fifo_push | output | 1 | Push fifo_wdata, one cycle |
| fifo_wdata | output | 16 | Word to push |
| board_init | output | 1 | Initialise pulse that also clears the FIFO, one cycle |

## Verification
The embedded properties watch the following on every clock:
- The driver enable is never high without the acknowledge.
- Pops and pushes respect the empty and full flags.
- At most one of pop, push, initialise and register request is active at a time.
- A pending register request holds steady until it is answered.
- The acknowledge is held while the strobe is low and is released only after the synchronised strobe has gone high.

Only the bench scenarios can show the rest:
- The returned data values and FIFO ordering.
- The Q result of each function code.
- The exact release latency.
- That the captured address and data survive later changes on the bus inputs.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_DISPATCH = 2'd1,
      ST_WAIT     = 2'd2,
      ST_RESP     = 2'd3
   } bfs_state_e;

   typedef enum logic [1:0] {
      OP_FIFO_RD = 2'd0,
      OP_FIFO_WR = 2'd1,
      OP_INIT    = 2'd2,
      OP_REG     = 2'd3
   } bfs_op_e;

endpackage

// File: rtl/bfs_strobe_sync.sv
module bfs_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bfs_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '1;
         prev <= 1'b1;
      end else begin
         pipe <= {pipe[STAGES-2:0], async_in};
         prev <= pipe[STAGES-1];
      end
   end

   assign level = pipe[STAGES-1];
   assign fall  = prev & ~pipe[STAGES-1];

endmodule

// File: rtl/bfs_fn_decode.sv
module bfs_fn_decode
   import bfs_pkg::*;
#(
   parameter int FUNC_W = 4
) (
   input  logic [FUNC_W-1:0] func,
   output bfs_op_e           op,
   output logic              is_read
);

   generate
      if (FUNC_W < 2) begin : g_bad_func
         $error("bfs_fn_decode: FUNC_W must be at least 2");
      end
   endgenerate

   localparam logic [FUNC_W-1:0] CODE_FIFO_RD = '0;
   localparam logic [FUNC_W-1:0] CODE_FIFO_WR = {1'b1, {(FUNC_W-1){1'b0}}};
   localparam logic [FUNC_W-1:0] CODE_INIT    = '1;

   always_comb begin
      is_read = ~func[FUNC_W-1];
      if (func == CODE_FIFO_RD)      op = OP_FIFO_RD;
      else if (func == CODE_FIFO_WR) op = OP_FIFO_WR;
      else if (func == CODE_INIT)    op = OP_INIT;
      else                           op = OP_REG;
   end

endmodule

// File: rtl/bus_fn_slave.sv
module bus_fn_slave
   import bfs_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int FUNC_W      = 4,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_strobe_n,
   input  logic [ADDR_W-1:0] bus_subaddr,
   input  logic [FUNC_W-1:0] bus_func,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdata_oe,
   output logic              bus_ack_n,
   output logic              bus_q,
   output logic              reg_req,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [FUNC_W-1:0] reg_func,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_ack,
   input  logic              reg_ok,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic [DATA_W-1:0] fifo_head,
   output logic              fifo_pop,
   output logic              fifo_push,
   output logic [DATA_W-1:0] fifo_wdata,
   output logic              board_init
);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bus_fn_slave: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   bfs_state_e        state;
   logic [ADDR_W-1:0] lat_addr;
   logic [FUNC_W-1:0] lat_func;
   logic [DATA_W-1:0] lat_wdata;
   logic [DATA_W-1:0] rd_q;
   logic              q_q;
   logic              ack_q;
   logic              oe_q;
   logic              strobe_lvl;
   logic              strobe_fall;
   bfs_op_e           op;
   logic              is_read;

   bfs_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (bus_strobe_n),
      .level    (strobe_lvl),
      .fall     (strobe_fall)
   );

   bfs_fn_decode #(.FUNC_W(FUNC_W)) u_decode (
      .func    (lat_func),
      .op      (op),
      .is_read (is_read)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_addr  <= '0;
         lat_func  <= '0;
         lat_wdata <= '0;
         rd_q      <= '0;
         q_q       <= 1'b0;
         ack_q     <= 1'b1;
         oe_q      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (strobe_fall) begin
                  lat_addr  <= bus_subaddr;
                  lat_func  <= bus_func;
                  lat_wdata <= bus_wdata;
                  state     <= ST_DISPATCH;
               end
            end
            ST_DISPATCH: begin
               case (op)
                  OP_FIFO_RD: begin
                     rd_q  <= fifo_empty ? '0 : fifo_head;
                     q_q   <= ~fifo_empty;
                     ack_q <= 1'b0;
                     oe_q  <= 1'b1;
                     state <= ST_RESP;
                  end
                  OP_FIFO_WR: begin
                     q_q   <= ~fifo_full;
                     ack_q <= 1'b0;
                     state <= ST_RESP;
                  end
                  OP_INIT: begin
                     q_q   <= 1'b1;
                     ack_q <= 1'b0;
                     state <= ST_RESP;
                  end
                  default: state <= ST_WAIT;
               endcase
            end
            ST_WAIT: begin
               if (reg_ack) begin
                  q_q   <= reg_ok;
                  if (is_read) rd_q <= reg_rdata;
                  ack_q <= 1'b0;
                  oe_q  <= is_read;
                  state <= ST_RESP;
               end
            end
            default: begin
               if (strobe_lvl) begin
                  ack_q <= 1'b1;
                  oe_q  <= 1'b0;
                  state <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign bus_rdata    = rd_q;
   assign bus_rdata_oe = oe_q;
   assign bus_ack_n    = ack_q;
   assign bus_q        = q_q;

   assign reg_req      = (state == ST_WAIT);
   assign reg_we       = ~is_read;
   assign reg_addr     = lat_addr;
   assign reg_func     = lat_func;
   assign reg_wdata    = lat_wdata;

   assign fifo_pop     = (state == ST_DISPATCH) && (op == OP_FIFO_RD) && !fifo_empty;
   assign fifo_push    = (state == ST_DISPATCH) && (op == OP_FIFO_WR) && !fifo_full;
   assign fifo_wdata   = lat_wdata;
   assign board_init   = (state == ST_DISPATCH) && (op == OP_INIT);

   // Assertions

   p_oe_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata_oe |-> !bus_ack_n);

   p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);

   p_push_notfull_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !fifo_full);

   p_single_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fifo_pop, fifo_push, board_init, reg_req}));

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_func)
                                 && $stable(reg_we) && $stable(reg_wdata)));

   p_ack_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ack_n && !strobe_lvl) |=> !bus_ack_n);

   p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack_n) |-> $past(strobe_lvl));

endmodule

// File: tb/bus_fn_slave_bench.sv
module bus_fn_slave_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_strobe_n = 1'b1;
   logic [10:0] bus_subaddr = '0;
   logic [3:0]  bus_func = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_rdata_oe, bus_ack_n, bus_q;
   logic        reg_req, reg_we;
   logic [10:0] reg_addr;
   logic [3:0]  reg_func;
   logic [15:0] reg_wdata;
   logic        reg_ack = 1'b0, reg_ok = 1'b0;
   logic [15:0] reg_rdata = '0;
   logic        fifo_empty, fifo_full, fifo_pop, fifo_push, board_init;
   logic [15:0] fifo_head, fifo_wdata;

   int compared = 0, mismatched = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bus_fn_slave u_bus_fn_slave (
      .clk(clk), .rst_n(rst_n), .bus_strobe_n(bus_strobe_n), .bus_subaddr(bus_subaddr),
      .bus_func(bus_func), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rdata_oe(bus_rdata_oe), .bus_ack_n(bus_ack_n), .bus_q(bus_q),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_func(reg_func),
      .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_ok(reg_ok), .reg_rdata(reg_rdata),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_head(fifo_head),
      .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
      .board_init(board_init)
   );

   // FIFO environment: 4 deep, show-ahead
   logic [15:0] fq [4];
   logic [1:0]  rd_p = '0, wr_p = '0;
   int          f_cnt = 0, pop_n = 0, push_n = 0, init_n = 0;
   logic [15:0] last_push = '0;
   assign fifo_empty = (f_cnt == 0);
   assign fifo_full  = (f_cnt == 4);
   assign fifo_head  = fq[rd_p];

   always @(posedge clk) begin
      if (board_init) begin
         init_n <= init_n + 1;
         f_cnt <= 0; rd_p <= '0; wr_p <= '0;
      end else begin
         if (fifo_pop)  begin pop_n <= pop_n + 1; rd_p <= rd_p + 2'd1; end
         if (fifo_push) begin
            push_n <= push_n + 1; fq[wr_p] <= fifo_wdata; wr_p <= wr_p + 2'd1;
            last_push <= fifo_wdata;
         end
         f_cnt <= f_cnt + (fifo_push ? 1 : 0) - (fifo_pop ? 1 : 0);
      end
   end

   // Register target environment
   logic [15:0] resp_mem [128];
   logic [15:0] exp_mem  [128];
   int          lat_cnt = 0, req_n = 0;
   logic [10:0] got_addr; logic [3:0] got_func; logic got_we; logic [15:0] got_wdata;

   function automatic int idx(input logic [3:0] f, input logic [10:0] a);
      return int'({f[2:0], a[3:0]});
   endfunction
   function automatic logic [15:0] init_val(input int i);
      return 16'(32'h3C00 + i * 7);
   endfunction
   function automatic logic ok_fn(input logic [10:0] a);
      return a[10:8] != 3'b111;
   endfunction

   always @(negedge clk) begin
      reg_ack <= 1'b0;
      if (reg_req && !reg_ack) begin
         if (lat_cnt == 0) begin
            reg_ack   <= 1'b1;
            reg_ok    <= ok_fn(reg_addr);
            reg_rdata <= (ok_fn(reg_addr) && !reg_we) ? resp_mem[idx(reg_func, reg_addr)] : 16'h0;
            if (reg_we && ok_fn(reg_addr)) resp_mem[idx(reg_func, reg_addr)] <= reg_wdata;
            got_addr <= reg_addr; got_func <= reg_func; got_we <= reg_we; got_wdata <= reg_wdata;
            req_n   <= req_n + 1;
            lat_cnt <= int'($urandom_range(0, 3));
         end else lat_cnt <= lat_cnt - 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_cycle(input logic [3:0] f, input logic [10:0] a, input logic [15:0] d,
                           input bit scramble);
      logic [15:0] e_data = '0;
      logic        e_q;
      bit          rd = (f[3] == 1'b0);
      int p0 = pop_n, u0 = push_n, i0 = init_n, r0 = req_n, rel = 0, w = 0;
      string tq;
      if (f == 4'd0) begin
         e_q = (f_cnt != 0); e_data = e_q ? fq[rd_p] : 16'h0; tq = e_q ? "R2" : "R3";
      end else if (f == 4'd8) begin
         e_q = (f_cnt != 4); tq = "R4";
      end else if (f == 4'd15) begin
         e_q = 1'b1; tq = "R5";
      end else begin
         e_q = ok_fn(a); tq = rd ? "R6" : "R7";
         if (rd && e_q) e_data = exp_mem[idx(f, a)];
      end
      bus_subaddr = a; bus_func = f; bus_wdata = d; bus_strobe_n = 1'b0;
      while (bus_ack_n && w < 200) begin
         @(negedge clk); w++;
         if (scramble && reg_req) begin
            bus_subaddr = ~a; bus_func = f ^ 4'h6; bus_wdata = ~d;
         end
      end
      chk("R9 ack seen", bus_ack_n, 1'b0);
      chk(rd ? "R8 oe on read" : "R8 oe off on write", bus_rdata_oe, rd);
      chk(tq, bus_q, e_q);
      if (rd) chk(tq, bus_rdata, e_data);
      if (f == 4'd0) begin
         chk("R2/R3 pop count", pop_n - p0, e_q ? 1 : 0);
      end else if (f == 4'd8) begin
         chk("R4 push count", push_n - u0, e_q ? 1 : 0);
         if (e_q) chk("R4 push data", last_push, d);
      end else if (f == 4'd15) begin
         chk("R5 init count", init_n - i0, 1);
         chk("R5 fifo cleared", f_cnt, 0);
         chk("R5 no reg req", req_n - r0, 0);
      end else begin
         chk("R10 one request", req_n - r0, 1);
         chk("R11 addr", got_addr, a);
         chk("R11 func", got_func, f);
         chk(tq, got_we, !rd);
         if (!rd) chk("R11 wdata", got_wdata, d);
         chk("R6 no fifo action", (pop_n - p0) + (push_n - u0), 0);
         if (!rd && e_q) exp_mem[idx(f, a)] = d;
      end
      repeat (3) begin
         @(negedge clk);
         chk("R9 ack held", bus_ack_n, 1'b0);
      end
      bus_strobe_n = 1'b1;
      while (!bus_ack_n && rel < 20) begin @(negedge clk); rel++; end
      chk("R9 release latency", rel, 3);
      chk("R8 oe dropped", bus_rdata_oe, 1'b0);
      repeat (2) @(negedge clk);
      chk("R9 no spurious ack", bus_ack_n, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++; compared++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      for (int i = 0; i < 128; i++) begin resp_mem[i] = init_val(i); exp_mem[i] = init_val(i); end
      repeat (3) @(negedge clk);
      chk("R1 ack", bus_ack_n, 1'b1);
      chk("R1 oe", bus_rdata_oe, 1'b0);
      chk("R1 q", bus_q, 1'b0);
      chk("R1 actions", {reg_req, fifo_pop, fifo_push, board_init}, 4'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {bus_ack_n, bus_rdata_oe, reg_req, fifo_pop, fifo_push, board_init}, 6'b100000);

      do_cycle(4'd0, 11'd3, 16'h0, 0);                 // R3 empty read
      for (int k = 0; k < 5; k++) do_cycle(4'd8, 11'(k), 16'hA000 + 16'(k), 0); // R4 fill + full
      for (int k = 0; k < 5; k++) do_cycle(4'd0, 11'd0, 16'h0, 0);  // R2 order, then R3
      do_cycle(4'd8, 11'd1, 16'h1234, 0);
      do_cycle(4'd8, 11'd2, 16'h5678, 0);
      do_cycle(4'd15, 11'd0, 16'h0, 0);                // R5 clear
      do_cycle(4'd0, 11'd0, 16'h0, 0);                 // R3 after clear
      do_cycle(4'd9, 11'd5, 16'hBEEF, 1);              // R7 + R11
      do_cycle(4'd1, 11'd5, 16'h0, 1);                 // R6 + R11
      do_cycle(4'd14, 11'h705, 16'h1111, 0);           // R7 rejected
      do_cycle(4'd7, 11'h7FF, 16'h0, 0);               // R6 rejected
      do_cycle(4'd7, 11'd2, 16'h0, 0);                 // R6 unwritten location

      for (int n = 0; n < 250; n++) begin
         logic [3:0]  f = 4'($urandom_range(0, 15));
         logic [10:0] a = 11'($urandom_range(0, 2047));
         if ($urandom_range(0, 3) == 0) f = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'd8;
         if ($urandom_range(0, 3) == 0) a[10:8] = 3'b111;
         do_cycle(f, a, 16'($urandom), bit'($urandom_range(0, 1)));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule